// File: doc/BRIEF.md
# ARINC 429 Label-Indexed Receive Store

This block takes fully assembled 32-bit ARINC 429 words from eight receive channels. It files each word in an on-chip table, at the slot given by its channel number and its 8-bit label (bits [7:0] of the word). A slot always holds the newest word seen for that label, so a host can read the current value of any label on any channel at any time. The block does no line decoding. Upstream logic hands over whole words through a valid/ready handshake per channel. When several channels offer a word in the same cycle, a round-robin arbiter accepts one per clock.

A programmable filter table holds two bits for each (channel, label) pair. Bit 0 copies the accepted word into that channel's 32-entry queue, from which the host pops the words in arrival order. Bit 1 raises a level interrupt. The interrupt holds until the host acknowledges it, and a register records the channel and label behind the most recent interrupt. A queue that is full drops new words and sets a sticky overflow flag, which the host clears by writing to it.

The host port is a one-cycle request interface. Every read returns its data one clock later with a valid strobe. Address bits [12:11] select the space. Bits [10:0] then carry {channel, label} or a channel number, as each requirement below states.

Top module: `a429_label_store`

## Requirements
- R1: After reset the interrupt output is low, every queue reads count 0 with its overflow flag clear, and every filter entry reads 0.
- R2: An accepted word is written to table slot {channel, word[7:0]} and replaces the value held there. A host read with hst_addr = {2'b00, channel[2:0], label[7:0]} returns the slot value with hst_rvalid high one cycle after the request.
- R3: A channel's word is accepted in a cycle where rx_ready is high for that channel. At most one rx_ready bit is high per cycle. Among waiting channels the first at or after the channel following the last accepted one wins, with channel 0 first after reset. A channel that holds rx_valid is served with no word lost.
- R4: The filter entry for (channel, label) is written and read at hst_addr = {2'b01, channel, label}, in data bits [1:0]. When bit 0 is set, an accepted word is appended to that channel's queue; otherwise the queue is untouched. A read at {2'b10, 8'b0, channel} pops the oldest queued word and returns it.
- R5: A queue holds 32 words. A word pushed into a full queue with no pop in the same cycle is discarded and sets that channel's overflow flag. The flag stays set until the host writes {2'b11, 8'b0, channel} with data bit 31 set. A status read at that address returns {overflow in bit 31, count in bits [5:0]}.
- R6: An accepted word whose filter bit 1 is set drives irq high from the next cycle on. irq stays high until irq_ack is sampled high. A read at {2'b11, 7'b0, 1'b1, 3'b0} returns {irq in bit 31, channel and label of the latest interrupt in bits [10:0]}.
- R7: If irq_ack and a word that raises an interrupt fall in the same cycle, irq stays high and the source register takes the new channel and label.
- R8: A pop and a push to the same full queue in the same cycle both take effect. The count stays 32 and no overflow is flagged.
- R9: A pop from an empty queue returns 0 and leaves the count at 0.
- R10: A filter value written by the host reads back unchanged. A filter write changes no other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 8 | Per-channel word offered |
| rx_word | input | 256 | Per-channel words, channel c in bits [32c+31:32c] |
| rx_ready | output | 8 | Per-channel word accepted this cycle |
| hst_req | input | 1 | Host access request |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | 13 | Host address: space in [12:11], index in [10:0] |
| hst_wdata | input | 32 | Host write data |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read request |
| hst_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, held until acknowledged |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
The sharpest same-cycle collision is a host pop and an arbiter push landing on one full queue together. The bench fills channel 2's queue to 32, then raises that channel's rx_valid in the very cycle it issues the pop. It judges the outcome by a status read that must show 32 words with overflow clear, and by the drained queue, which must end with the pushed word. A second collision lines up irq_ack with a new interrupt-marked word, and the bench requires irq to stay high with the source register naming the new label.

// File: rtl/a429_ls_pkg.sv
package a429_ls_pkg;

    // host address space select, hst_addr[12:11]
    typedef enum logic [1:0] {
        SP_TABLE = 2'd0,
        SP_FILT  = 2'd1,
        SP_POP   = 2'd2,
        SP_STAT  = 2'd3
    } space_e;

    // filter entry bit meanings
    localparam int FLT_QUEUE_BIT = 0;
    localparam int FLT_IRQ_BIT   = 1;

endpackage

// File: rtl/a429_ls_rr_arb.sv
module a429_ls_rr_arb #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;
    int      k;

    always_comb begin
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        k       = 0;
        for (int i = 0; i < N; i++) begin
            k = (int'(st_q.ptr) + i) % N;
            if (!gnt_any && req[k]) begin
                gnt_any = 1'b1;
                gnt[k]  = 1'b1;
                gnt_idx = IW'(k);
            end
        end
        if (gnt_any) begin
            st_d.ptr = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R3
    gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & ~req) == '0));

endmodule

// File: rtl/a429_ls_chq.sv
module a429_ls_chq #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          drop
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } q_st_t;

    q_st_t      st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic       do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt < CW'(DEPTH)) || do_pop);
        drop    = push && !do_push;
        if (do_push) begin
            st_d.wptr = (int'(st_q.wptr) == DEPTH - 1) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rptr = (int'(st_q.rptr) == DEPTH - 1) ? '0 : st_q.rptr + 1'b1;
        end
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= din;
    end

    assign dout  = mem[st_q.rptr];
    assign count = st_q.cnt;
    assign empty = (st_q.cnt == '0);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CW'(DEPTH)));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/a429_ls_table.sv
module a429_ls_table #(
    parameter int DW      = 32,
    parameter int ENTRIES = 2048,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [ENTRIES];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/a429_label_store.sv
module a429_label_store
    import a429_ls_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int WORD_W  = 32,
    parameter int LBL_W   = 8,
    parameter int Q_DEPTH = 32,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int SLOT_W = CH_W + LBL_W,
    localparam int SLOTS  = NUM_CH << LBL_W,
    localparam int ADDR_W = SLOT_W + 2,
    localparam int QC_W   = $clog2(Q_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        rx_valid,
    input  logic [NUM_CH*WORD_W-1:0] rx_word,
    output logic [NUM_CH-1:0]        rx_ready,
    input  logic                     hst_req,
    input  logic                     hst_we,
    input  logic [ADDR_W-1:0]        hst_addr,
    input  logic [WORD_W-1:0]        hst_wdata,
    output logic                     hst_rvalid,
    output logic [WORD_W-1:0]        hst_rdata,
    output logic                     irq,
    input  logic                     irq_ack
);

    typedef struct packed {
        logic              irq;
        logic [SLOT_W-1:0] src;
        logic [NUM_CH-1:0] ovf;
        logic              rvalid;
        logic              rsel_tbl;
        logic [WORD_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    // arbitration
    logic [NUM_CH-1:0] gnt;
    logic [CH_W-1:0]   gnt_idx;
    logic              gnt_any;

    a429_ls_rr_arb #(.N(NUM_CH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (rx_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    assign rx_ready = gnt;

    logic [WORD_W-1:0] win_word;
    logic [SLOT_W-1:0] win_slot;
    logic [1:0]        win_flt;

    assign win_word = rx_word[int'(gnt_idx)*WORD_W +: WORD_W];
    assign win_slot = {gnt_idx, win_word[LBL_W-1:0]};

    // host decode
    space_e            h_space;
    logic [SLOT_W-1:0] h_slot;
    logic [CH_W-1:0]   h_ch;
    logic              h_sub, h_rd, h_wr;

    assign h_space = space_e'(hst_addr[ADDR_W-1 -: 2]);
    assign h_slot  = hst_addr[SLOT_W-1:0];
    assign h_ch    = hst_addr[CH_W-1:0];
    assign h_sub   = hst_addr[CH_W];
    assign h_rd    = hst_req && !hst_we;
    assign h_wr    = hst_req && hst_we;

    logic unused_wbits;
    assign unused_wbits = ^hst_wdata[WORD_W-2:2];

    // filter table
    logic [1:0] filt_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) filt_q[i] <= 2'b00;
        end else if (h_wr && h_space == SP_FILT) begin
            filt_q[h_slot] <= hst_wdata[1:0];
        end
    end

    assign win_flt = gnt_any ? filt_q[win_slot] : 2'b00;

    // latest-value table
    logic [WORD_W-1:0] tbl_rdata;

    a429_ls_table #(.DW(WORD_W), .ENTRIES(SLOTS)) u_table (
        .clk   (clk),
        .we    (gnt_any),
        .waddr (win_slot),
        .wdata (win_word),
        .re    (h_rd && h_space == SP_TABLE),
        .raddr (h_slot),
        .rdata (tbl_rdata)
    );

    // per-channel queues
    logic [WORD_W-1:0] q_dout  [NUM_CH];
    logic [QC_W-1:0]   q_cnt   [NUM_CH];
    logic [NUM_CH-1:0] q_empty;
    logic [NUM_CH-1:0] q_drop;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_q
        a429_ls_chq #(.W(WORD_W), .DEPTH(Q_DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (gnt[c] && win_flt[FLT_QUEUE_BIT]),
            .pop   (h_rd && h_space == SP_POP && int'(h_ch) == c),
            .din   (win_word),
            .dout  (q_dout[c]),
            .count (q_cnt[c]),
            .empty (q_empty[c]),
            .drop  (q_drop[c])
        );
    end

    // next state
    always_comb begin
        st_d          = st_q;
        st_d.rvalid   = 1'b0;
        st_d.rsel_tbl = 1'b0;

        if (h_wr && h_space == SP_STAT && !h_sub && hst_wdata[WORD_W-1]) begin
            st_d.ovf[h_ch] = 1'b0;
        end
        st_d.ovf = st_d.ovf | q_drop;

        if (irq_ack) st_d.irq = 1'b0;
        if (win_flt[FLT_IRQ_BIT]) begin
            st_d.irq = 1'b1;
            st_d.src = win_slot;
        end

        if (h_rd) begin
            st_d.rvalid = 1'b1;
            unique case (h_space)
                SP_TABLE: st_d.rsel_tbl = 1'b1;
                SP_FILT:  st_d.rdata = {{(WORD_W-2){1'b0}}, filt_q[h_slot]};
                SP_POP:   st_d.rdata = q_empty[h_ch] ? '0 : q_dout[h_ch];
                SP_STAT: begin
                    if (h_sub) st_d.rdata = {st_q.irq, {(WORD_W-1-SLOT_W){1'b0}}, st_q.src};
                    else       st_d.rdata = {st_q.ovf[h_ch], {(WORD_W-1-QC_W){1'b0}}, q_cnt[h_ch]};
                end
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hst_rvalid = st_q.rvalid;
    assign hst_rdata  = st_q.rsel_tbl ? tbl_rdata : st_q.rdata;
    assign irq        = st_q.irq;

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(gnt_any));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_ack));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(st_q.ovf) & ~st_q.ovf)) |-> $past(h_wr && h_space == SP_STAT));

endmodule

// File: tb/a429_label_store_bench.sv
`timescale 1ns/1ps
module a429_label_store_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   rx_valid = '0;
    logic [255:0] rx_word = '0;
    logic [7:0]   rx_ready;
    logic         hst_req = 1'b0, hst_we = 1'b0;
    logic [12:0]  hst_addr = '0;
    logic [31:0]  hst_wdata = '0;
    logic         hst_rvalid;
    logic [31:0]  hst_rdata;
    logic         irq;
    logic         irq_ack = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    a429_label_store u_a429_label_store (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
        .rx_ready(rx_ready), .hst_req(hst_req), .hst_we(hst_we),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rvalid(hst_rvalid),
        .hst_rdata(hst_rdata), .irq(irq), .irq_ack(irq_ack)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] a_tbl(int ch, int lbl);
        return {2'b00, 3'(ch), 8'(lbl)};
    endfunction
    function automatic logic [12:0] a_flt(int ch, int lbl);
        return {2'b01, 3'(ch), 8'(lbl)};
    endfunction
    function automatic logic [12:0] a_pop(int ch);
        return {2'b10, 8'h00, 3'(ch)};
    endfunction
    function automatic logic [12:0] a_st(int ch);
        return {2'b11, 8'h00, 3'(ch)};
    endfunction
    localparam logic [12:0] A_SRC = {2'b11, 7'h00, 1'b1, 3'b000};

    // monitor: compares read results against scoreboard
    always @(negedge clk) begin
        if (rst_n && hst_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R2: unexpected read data actual %h expected none", hst_rdata);
            end else begin
                check(tag_q.pop_front(), hst_rdata, exp_q.pop_front());
            end
        end
    end

    // driver tasks, entered and left at a falling edge
    task automatic host_rd(logic [12:0] a, logic [31:0] e, string t);
        hst_req = 1'b1; hst_we = 1'b0; hst_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        hst_req = 1'b0;
    endtask

    task automatic host_wr(logic [12:0] a, logic [31:0] d);
        hst_req = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_req = 1'b0; hst_we = 1'b0;
    endtask

    task automatic send(int c, logic [31:0] w);
        rx_word[c*32 +: 32] = w;
        rx_valid[c] = 1'b1;
        #1;
        while (!rx_ready[c]) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        rx_valid[c] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        for (int c = 0; c < 8; c++) host_rd(a_st(c), 32'h0, "R1 queue status");
        host_rd(a_flt(0, 8'h00), 32'h0, "R1 filter low");
        host_rd(a_flt(7, 8'hFF), 32'h0, "R1 filter high");

        // R3 round robin from channel 0
        rx_word[1*32 +: 32] = 32'h1234_5611;
        rx_word[3*32 +: 32] = 32'h0BAD_F033;
        rx_word[5*32 +: 32] = 32'h7777_7755;
        rx_valid = 8'b0010_1010;
        #1 check("R3 grant ch1", {24'b0, rx_ready}, 32'h02);
        @(negedge clk); rx_valid[1] = 1'b0;
        #1 check("R3 grant ch3", {24'b0, rx_ready}, 32'h08);
        @(negedge clk); rx_valid[3] = 1'b0;
        #1 check("R3 grant ch5", {24'b0, rx_ready}, 32'h20);
        @(negedge clk); rx_valid[5] = 1'b0;
        rx_word[0*32 +: 32] = 32'h0000_5A00;
        rx_word[6*32 +: 32] = 32'h6666_66A6;
        rx_valid = 8'b0100_0001;
        #1 check("R3 grant ch6 after wrap", {24'b0, rx_ready}, 32'h40);
        @(negedge clk); rx_valid[6] = 1'b0;
        #1 check("R3 grant ch0", {24'b0, rx_ready}, 32'h01);
        @(negedge clk); rx_valid[0] = 1'b0;

        // R2 table contents
        host_rd(a_tbl(1, 8'h11), 32'h1234_5611, "R2 ch1 slot");
        host_rd(a_tbl(3, 8'h33), 32'h0BAD_F033, "R2 ch3 slot");
        host_rd(a_tbl(5, 8'h55), 32'h7777_7755, "R2 ch5 slot");
        host_rd(a_tbl(6, 8'hA6), 32'h6666_66A6, "R2 ch6 slot");
        host_rd(a_tbl(0, 8'h00), 32'h0000_5A00, "R2 ch0 slot");
        host_rd(a_st(1), 32'h0, "R4 unfiltered word not queued");
        check("R6 no irq without filter", {31'b0, irq}, 32'h0);
        send(1, 32'hCAFE_BE11);
        host_rd(a_tbl(1, 8'h11), 32'hCAFE_BE11, "R2 overwrite");

        // R10 filter programming
        host_wr(a_flt(2, 8'h40), 32'h1);
        host_wr(a_flt(2, 8'h41), 32'h2);
        host_wr(a_flt(4, 8'h80), 32'h3);
        host_rd(a_flt(2, 8'h40), 32'h1, "R10 filter ch2 40");
        host_rd(a_flt(2, 8'h41), 32'h2, "R10 filter ch2 41");
        host_rd(a_flt(4, 8'h80), 32'h3, "R10 filter ch4 80");
        host_rd(a_flt(2, 8'h42), 32'h0, "R10 neighbour untouched");

        // R4 queue order
        send(2, 32'h0000_0140);
        send(2, 32'h0000_0042);
        send(2, 32'h0000_0240);
        send(2, 32'h0000_0340);
        host_rd(a_st(2), 32'h3, "R4 queue count");
        host_rd(a_pop(2), 32'h0000_0140, "R4 pop first");
        host_rd(a_pop(2), 32'h0000_0240, "R4 pop second");
        host_rd(a_pop(2), 32'h0000_0340, "R4 pop third");
        host_rd(a_pop(2), 32'h0, "R9 pop empty");
        host_rd(a_st(2), 32'h0, "R9 count stays zero");

        // R6 interrupt
        send(2, 32'h0000_1141);
        check("R6 irq raised", {31'b0, irq}, 32'h1);
        host_rd(A_SRC, 32'h8000_0241, "R6 source register");
        repeat (4) @(negedge clk);
        check("R6 irq held", {31'b0, irq}, 32'h1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R6 irq cleared by ack", {31'b0, irq}, 32'h0);
        host_rd(A_SRC, 32'h0000_0241, "R6 source kept after ack");

        // R7 ack collides with new interrupt
        send(2, 32'h0000_2241);
        rx_word[4*32 +: 32] = 32'hFFFF_FF80;
        rx_valid[4] = 1'b1; irq_ack = 1'b1;
        #1 check("R7 ch4 accepted", {24'b0, rx_ready}, 32'h10);
        @(negedge clk); rx_valid[4] = 1'b0; irq_ack = 1'b0;
        check("R7 irq stays high", {31'b0, irq}, 32'h1);
        host_rd(A_SRC, 32'h8000_0480, "R7 source updated");
        host_rd(a_pop(4), 32'hFFFF_FF80, "R4 ch4 queued");
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;

        // R8 and R5 full queue
        for (int i = 0; i < 32; i++) send(2, 32'((i << 8) | 8'h40));
        host_rd(a_st(2), 32'h0000_0020, "R5 queue full");
        rx_word[2*32 +: 32] = 32'hBEEF_0040;
        rx_valid[2] = 1'b1;
        hst_req = 1'b1; hst_we = 1'b0; hst_addr = a_pop(2);
        exp_q.push_back(32'h0000_0040); tag_q.push_back("R8 pop during push");
        #1 check("R8 push accepted", {24'b0, rx_ready}, 32'h04);
        @(negedge clk); rx_valid[2] = 1'b0; hst_req = 1'b0;
        host_rd(a_st(2), 32'h0000_0020, "R8 no overflow");
        send(2, 32'hDEAD_0040);
        host_rd(a_st(2), 32'h8000_0020, "R5 overflow set");
        repeat (3) @(negedge clk);
        host_rd(a_st(2), 32'h8000_0020, "R5 overflow sticky");
        host_wr(a_st(2), 32'h8000_0000);
        host_rd(a_st(2), 32'h0000_0020, "R5 overflow cleared");
        for (int i = 1; i < 32; i++) host_rd(a_pop(2), 32'((i << 8) | 8'h40), "R5 drain order");
        host_rd(a_pop(2), 32'hBEEF_0040, "R8 pushed word last");
        host_rd(a_pop(2), 32'h0, "R5 dropped word absent");

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule